// File: doc/BRIEF.md
# Latched Fault Status Interrupt Register

This block is the read-only fault status register of a smart-card interface controller. It holds four sticky fault flags: an overload on the card supply or card reset pin, the supply supervisor, a change in card presence, and an overtemperature. While the protection, presence or overtemperature flag is pending, or while the power-on-reset pulse is high, it pulls an active-low interrupt line low. Whenever any flag goes from clear to set, it sends a one-cycle pulse that forces the session-start control bit of the controller to zero. This starts an emergency deactivation of the card.

Software reads the register over a simple parallel bus with an active-low read strobe and a 4-bit address. The strobe is synchronised into the internal clock domain. On the synchronised falling edge the block takes a snapshot of the flags, and the data bus presents that snapshot until the strobe ends. A fixed number of internal clocks after the synchronised rising edge, the block clears the flags that were in the snapshot. The supervisor flag is cleared only when the read took place outside the power-on-reset pulse.

Top module: `fault_status_reg`

## Requirements
- R1: After reset, `rdata` is 0, `irq_n` is 1, `start_clr` is 0 and a read of the register returns 0.
- R2: The register is at address 0x0F. Its bit positions are: bit 5 = protection flag, set when `vcc_ovl` or `rst_ovl` is high; bit 4 = supervisor flag; bit 2 = presence-change flag; bit 0 = overtemperature flag. Bits 7, 6, 3 and 1 always read 0.
- R3: `irq_n` is 0 while the protection, presence or overtemperature flag is set, or while `por_pulse` is high. Otherwise `irq_n` is 1. The supervisor flag on its own does not hold `irq_n` low.
- R4: While a read strobe is active at address 0x0F, `rdata` carries the flag values captured when the strobe began. At any other time, and during a read of any other address, `rdata` is 0. A read of any other address clears nothing.
- R5: A read of address 0x0F clears only the flags that were captured in its snapshot. The clear takes effect on the fifth clock edge after `rd_n` rises: two edges for the synchroniser and `CLR_DLY`=2 edges of delay, applied on the next edge.
- R6: The supervisor flag is set while `por_pulse` is high. A read that begins while `por_pulse` is high, or a clear that falls inside the pulse, leaves the flag set. A read made entirely outside the pulse clears it.
- R7: The presence-change flag is set by either a rising or a falling edge of `card_present`, after a two-flop synchroniser.
- R8: If a fault input is active in the same cycle as the clear, its flag stays set.
- R9: `start_clr` is high for exactly one cycle, in the first cycle in which a flag is newly set. It stays low while flags only remain set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_pulse | input | 1 | Power-on-reset / supply drop-out pulse, active high |
| vcc_ovl | input | 1 | Card supply overload event |
| rst_ovl | input | 1 | Card reset pin overload event |
| card_present | input | 1 | Asynchronous card presence level |
| overtemp | input | 1 | Overtemperature event |
| rd_n | input | 1 | Active-low read strobe (asynchronous) |
| addr | input | 4 | Read address, held stable during the strobe |
| rdata | output | 8 | Read data |
| irq_n | output | 1 | Active-low interrupt |
| start_clr | output | 1 | One-cycle pulse that forces the start control bit to zero |

## Verification
The hardest case to reach from the ports is a fault that coincides with the clear, or that arrives between the snapshot and the clear. The bench reaches the first by holding `overtemp` high across a whole read, so the event is present on the clearing edge. It reaches the second by toggling `card_present` after the strobe has fallen, so the presence flag must survive into the next read. The power-on-reset case is driven by starting a read inside the pulse and repeating the read after the pulse ends.

// File: rtl/fault_status_reg.sv
module fault_status_reg #(
  parameter int ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 4'hF,
  parameter int CLR_DLY  = 2,
  parameter int SYNC_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_pulse,
  input  logic              vcc_ovl,
  input  logic              rst_ovl,
  input  logic              card_present,
  input  logic              overtemp,
  input  logic              rd_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        rdata,
  output logic              irq_n,
  output logic              start_clr
);

  localparam int BIT_PROT = 5;
  localparam int BIT_SUPL = 4;
  localparam int BIT_PRES = 2;
  localparam int BIT_TEMP = 0;

  logic prot_q, supl_q, pres_q, temp_q;
  logic [SYNC_W-1:0] rd_sh, pres_sh;
  logic rd_prev, pres_prev;
  logic reading, sel_q, outside_q;
  logic [7:0] snap;
  logic [CLR_DLY-1:0] clr_pipe;

  wire rd_sync   = rd_sh[SYNC_W-1];
  wire pres_sync = pres_sh[SYNC_W-1];
  wire rd_fall   = rd_prev & ~rd_sync;
  wire rd_rise   = ~rd_prev & rd_sync;
  wire clr       = clr_pipe[CLR_DLY-1];

  wire [7:0] status = {2'b00, prot_q, supl_q, 1'b0, pres_q, 1'b0, temp_q};

  wire prot_set = vcc_ovl | rst_ovl;
  wire supl_set = por_pulse;
  wire pres_set = pres_sync ^ pres_prev;
  wire temp_set = overtemp;

  wire prot_clr = clr & snap[BIT_PROT];
  wire supl_clr = clr & snap[BIT_SUPL] & outside_q & ~por_pulse;
  wire pres_clr = clr & snap[BIT_PRES];
  wire temp_clr = clr & snap[BIT_TEMP];

  wire prot_nxt = prot_set | (prot_q & ~prot_clr);
  wire supl_nxt = supl_set | (supl_q & ~supl_clr);
  wire pres_nxt = pres_set | (pres_q & ~pres_clr);
  wire temp_nxt = temp_set | (temp_q & ~temp_clr);

  wire any_rise = (prot_nxt & ~prot_q) | (supl_nxt & ~supl_q) |
                  (pres_nxt & ~pres_q) | (temp_nxt & ~temp_q);

  assign rdata = (reading & sel_q) ? snap : 8'h00;
  assign irq_n = ~(prot_q | pres_q | temp_q | por_pulse);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_sh     <= '1;
      pres_sh   <= '0;
      rd_prev   <= 1'b1;
      pres_prev <= 1'b0;
    end else begin
      rd_sh     <= (rd_sh << 1) | SYNC_W'(rd_n);
      pres_sh   <= (pres_sh << 1) | SYNC_W'(card_present);
      rd_prev   <= rd_sync;
      pres_prev <= pres_sync;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reading   <= 1'b0;
      sel_q     <= 1'b0;
      outside_q <= 1'b0;
      snap      <= '0;
      clr_pipe  <= '0;
    end else begin
      if (rd_fall) begin
        reading   <= 1'b1;
        sel_q     <= (addr == REG_ADDR);
        outside_q <= ~por_pulse;
        snap      <= status;
      end else if (rd_rise) begin
        reading   <= 1'b0;
      end
      clr_pipe <= (clr_pipe << 1) | CLR_DLY'(rd_rise & reading & sel_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q    <= 1'b0;
      supl_q    <= 1'b0;
      pres_q    <= 1'b0;
      temp_q    <= 1'b0;
      start_clr <= 1'b0;
    end else begin
      prot_q    <= prot_nxt;
      supl_q    <= supl_nxt;
      pres_q    <= pres_nxt;
      temp_q    <= temp_nxt;
      start_clr <= any_rise;
    end
  end

  assert_supl_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    por_pulse |=> supl_q);

  assert_supl_kept_in_por_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (supl_q && por_pulse) |=> supl_q);

  assert_start_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_clr |=> !start_clr);

  assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && overtemp) |=> temp_q);

  assert_clear_only_by_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(temp_q) |-> $past(clr));

  assert_data_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_sync) |=> (rdata == 8'h00));

endmodule

// File: tb/fault_status_reg_test.sv
module fault_status_reg_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por_pulse = 1'b0, vcc_ovl = 1'b0, rst_ovl = 1'b0;
  logic card_present = 1'b0, overtemp = 1'b0, rd_n = 1'b1;
  logic [3:0] addr = 4'h0;
  logic [7:0] rdata;
  logic irq_n, start_clr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] val; string req; } exp_t;
  exp_t exp_q[$];
  event sample_ev;

  always #2 clk = ~clk;

  fault_status_reg uut (
    .clk(clk), .rst_n(rst_n), .por_pulse(por_pulse), .vcc_ovl(vcc_ovl),
    .rst_ovl(rst_ovl), .card_present(card_present), .overtemp(overtemp),
    .rd_n(rd_n), .addr(addr), .rdata(rdata), .irq_n(irq_n), .start_clr(start_clr)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  always @(sample_ev) begin
    exp_t e;
    if (exp_q.size() == 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: actual %02h expected none", rdata);
    end else begin
      e = exp_q.pop_front();
      check(rdata, e.val, e.req);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_reg(input logic [3:0] a, input logic [7:0] exp, input string req);
    exp_t e;
    addr = a; rd_n = 1'b0;
    cyc(5);
    e.val = exp; e.req = req;
    exp_q.push_back(e);
    -> sample_ev;
    cyc(1);
    rd_n = 1'b1;
    cyc(8);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; cyc(1); s = 1'b0; cyc(3);
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 20000) begin
      @(posedge clk); wd++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual expired expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1 reset state
    check(rdata, 8'h00, "R1 rdata");
    check({7'b0, irq_n}, 8'h01, "R1 irq_n");
    check({7'b0, start_clr}, 8'h00, "R1 start_clr");
    read_reg(4'hF, 8'h00, "R1 read");

    // R6 / R3 / R9 power-on pulse
    por_pulse = 1'b1;
    cyc(1);
    check({7'b0, start_clr}, 8'h01, "R9 pulse on supl");
    cyc(1);
    check({7'b0, start_clr}, 8'h00, "R9 single cycle");
    check({7'b0, irq_n}, 8'h00, "R3 irq during por");
    read_reg(4'hF, 8'h10, "R6 read inside por");
    por_pulse = 1'b0;
    cyc(2);
    check({7'b0, irq_n}, 8'h01, "R3 supl alone no irq");
    read_reg(4'hF, 8'h10, "R6 supl kept");
    read_reg(4'hF, 8'h00, "R6 supl cleared outside por");

    // R2 protection from either pin
    pulse(vcc_ovl);
    check({7'b0, irq_n}, 8'h00, "R3 irq on prot");
    read_reg(4'hF, 8'h20, "R2 vcc overload bit5");
    check({7'b0, irq_n}, 8'h01, "R3 irq released");
    pulse(rst_ovl);
    read_reg(4'hF, 8'h20, "R2 rst overload bit5");

    // R4 wrong address clears nothing
    pulse(overtemp);
    read_reg(4'h9, 8'h00, "R4 other address");
    check({7'b0, irq_n}, 8'h00, "R4 flag kept after other address");

    // R5 clear timing
    addr = 4'hF; rd_n = 1'b0;
    cyc(5);
    check(rdata, 8'h01, "R5 snapshot");
    rd_n = 1'b1;
    cyc(4);
    check({7'b0, irq_n}, 8'h00, "R5 not yet cleared");
    cyc(1);
    check({7'b0, irq_n}, 8'h01, "R5 cleared on fifth edge");
    check(rdata, 8'h00, "R4 rdata idle after strobe");
    cyc(4);

    // R7 presence both edges
    card_present = 1'b1; cyc(5);
    read_reg(4'hF, 8'h04, "R7 rising presence");
    card_present = 1'b0; cyc(5);
    read_reg(4'hF, 8'h04, "R7 falling presence");
    read_reg(4'hF, 8'h00, "R7 cleared");

    // R8 event during clear
    overtemp = 1'b1; cyc(2);
    read_reg(4'hF, 8'h01, "R8 first read");
    check({7'b0, irq_n}, 8'h00, "R8 flag survives clear");
    overtemp = 1'b0; cyc(1);
    read_reg(4'hF, 8'h01, "R8 second read");
    read_reg(4'hF, 8'h00, "R8 finally clear");

    // R5 event after snapshot survives
    pulse(overtemp);
    addr = 4'hF; rd_n = 1'b0;
    cyc(4);
    card_present = 1'b1;
    cyc(1);
    check(rdata, 8'h01, "R5 snapshot excludes late event");
    rd_n = 1'b1;
    cyc(8);
    read_reg(4'hF, 8'h04, "R5 late presence kept");

    // R2 combined layout
    vcc_ovl = 1'b1; overtemp = 1'b1; card_present = 1'b0;
    cyc(1); vcc_ovl = 1'b0; overtemp = 1'b0; cyc(5);
    read_reg(4'hF, 8'h25, "R2 combined bits");
    read_reg(4'hF, 8'h00, "R2 all cleared");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule